// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes a single memory request from a group of 32 lanes, where each lane names one 4-byte word and carries an active bit. A flag on the request marks it as a load or a store. The block groups the active lanes by the aligned segment that holds their word and emits one transaction per distinct segment.

Each transaction carries the segment base address and a word-enable mask with one bit for each 4-byte word of that segment. Transactions leave one per cycle on a valid/ready handshake, lowest segment address first.

After the final transaction of a request has been accepted, the block raises a one-cycle completion pulse together with the number of transactions it issued. Only then does it take the next request. A read-modify-write is two separate requests, one load and one store, so it costs two full sets of transactions.

Top module: `warp_coalescer`

## Requirements
- R1: 32 active lanes reading consecutive words that start on a segment boundary produce exactly one transaction. Its address is that boundary and every word-enable bit is set (with the default 128-byte segment).
- R2: The same consecutive pattern shifted by one word, so that it straddles a segment boundary, produces exactly two transactions.
- R3: A consecutive pattern shifted by a whole multiple of the segment size produces exactly one transaction.
- R4: A stride of two words across 32 lanes produces two transactions. A stride of four words produces four transactions.
- R5: Lanes whose mask bit is 0 contribute no transaction and no enable bit. A request with an all-zero mask issues no transaction and completes with a count of 0.
- R6: Transactions of one request are issued in strictly ascending segment address order. Each segment is issued once, even when several lanes hit the same word.
- R7: The segment address is the lane address with its low log2(SEG_BYTES) bits cleared. Word-enable bit k is set exactly when some active lane's address bits [log2(SEG_BYTES)-1:2] equal k and the lane falls in that segment.
- R8: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_addr`, `txn_word_en` and `txn_store` hold their values into the next cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the last transaction handshake (or two cycles after accepting an empty request). `done_count` then equals the number of transactions handed over for that request.
- R10: `txn_store` repeats the request's store flag. Loads and stores are coalesced alike, so a load followed by a store of the same pattern issues the same transactions twice.
- R11: `req_ready` is high only while no request is in flight, and `txn_valid` is never high at the same time. After reset, `req_ready` is 1 and `txn_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_lane_addr | input | LANES*ADDR_W | Byte address of each lane; lane i at bits [i*ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Active bit per lane |
| req_store | input | 1 | 1 = store, 0 = load |
| txn_valid | output | 1 | A segment transaction is offered |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_addr | output | ADDR_W | Segment-aligned base address |
| txn_word_en | output | SEG_BYTES/4 | One enable bit per word of the segment |
| txn_store | output | 1 | Store flag of the request in flight |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | $clog2(LANES+1) | Transactions issued for the finished request |

## Verification
Directed requests cover these cases:
- An aligned unit-stride pattern, which must give one transaction.
- The same pattern shifted by one word, which must give two.
- The same pattern shifted by a whole segment, which must give one.
- Strides of two and four words, which must give two and four.

Together these separate a design that groups by segment from one that merges only adjacent lanes or counts per lane.

Further directed requests use an all-zero mask, a sparse mask, and lanes that collide on one word. These show whether inactive lanes are really dropped and whether duplicates are folded into one enable bit.

Random requests mix strides, bases and masks under random backpressure, and are checked against a bench model of the distinct-segment set. This checks ordering, enable masks and the reported count when `txn_ready` stalls.

// File: rtl/warp_coal_pkg.sv
// Shared definitions for the warp coalescer.
// Assumes lane addresses are byte addresses of 4-byte words.
package warp_coal_pkg;
    localparam int WORD_BYTES = 4;
    localparam int WORD_LSB   = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } coal_state_e;
endpackage

// File: rtl/coal_seg_pick.sv
// Finds the lowest segment touched by any still-pending lane.
// Assumes SEG_LSB < ADDR_W; 'any_pending' is low when no lane is left.
module coal_seg_pick #(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 32,
    parameter int SEG_LSB = 7
) (
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    input  logic [LANES-1:0]        pending,
    output logic [ADDR_W-1:0]       seg_base,
    output logic                    any_pending
);
    localparam int SEG_W = ADDR_W - SEG_LSB;

    logic [SEG_W-1:0] best;

    // Linear minimum search over the pending lanes' segment numbers.
    always_comb begin
        best        = '1;
        any_pending = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (pending[i] &&
                (!any_pending || lane_addr[i*ADDR_W+SEG_LSB +: SEG_W] < best)) begin
                best        = lane_addr[i*ADDR_W+SEG_LSB +: SEG_W];
                any_pending = 1'b1;
            end
        end
        seg_base = {best, {SEG_LSB{1'b0}}};
    end
endmodule

// File: rtl/coal_seg_gather.sv
// Marks the pending lanes that fall in the chosen segment and builds the
// word-enable mask of that segment from their word indices.
// Assumes segments hold at least two words (SEG_LSB > 2).
module coal_seg_gather #(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 32,
    parameter int SEG_LSB = 7,
    parameter int WORDS   = 32
) (
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    input  logic [LANES-1:0]        pending,
    input  logic [ADDR_W-1:0]       seg_base,
    output logic [LANES-1:0]        hit,
    output logic [WORDS-1:0]        word_en
);
    import warp_coal_pkg::*;

    localparam int SEG_W  = ADDR_W - SEG_LSB;
    localparam int WIDX_W = SEG_LSB - WORD_LSB;

    logic [WIDX_W-1:0] widx [LANES];

    // Per-lane segment match and word index inside the segment.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit[g]  = pending[g] &&
                         (lane_addr[g*ADDR_W+SEG_LSB +: SEG_W] == seg_base[ADDR_W-1:SEG_LSB]);
        assign widx[g] = lane_addr[g*ADDR_W+WORD_LSB +: WIDX_W];
    end

    // OR every matching lane's word bit into the enable mask.
    always_comb begin
        word_en = '0;
        for (int i = 0; i < LANES; i++) begin
            if (hit[i]) word_en[widx[i]] = 1'b1;
        end
    end
endmodule

// File: rtl/warp_coalescer.sv
// Top of the coalescer. It latches one warp request, then issues one
// segment transaction per cycle (lowest address first), retiring the lanes
// each accepted transaction covers. It pulses 'done' with the transaction
// count once no lane is left.
// Assumes word-aligned lane addresses and a power-of-two SEG_BYTES >= 8.
module warp_coalescer #(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    localparam int SEG_LSB  = $clog2(SEG_BYTES),
    localparam int WORDS    = SEG_BYTES / 4,
    localparam int CNT_W    = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_lane_addr,
    input  logic [LANES-1:0]        req_mask,
    input  logic                    req_store,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_addr,
    output logic [WORDS-1:0]        txn_word_en,
    output logic                    txn_store,
    output logic                    done,
    output logic [CNT_W-1:0]        done_count
);
    import warp_coal_pkg::*;

    coal_state_e             state_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        pending_q;
    logic                    store_q;
    logic [CNT_W-1:0]        cnt_q;
    logic                    done_q;
    logic [CNT_W-1:0]        done_cnt_q;

    logic [ADDR_W-1:0] seg_base;
    logic              any_pending;
    logic [LANES-1:0]  hit;
    logic [WORDS-1:0]  word_en;
    logic [LANES-1:0]  left;
    logic              fire;

    coal_seg_pick #(
        .LANES(LANES), .ADDR_W(ADDR_W), .SEG_LSB(SEG_LSB)
    ) u_pick (
        .lane_addr(addr_q), .pending(pending_q),
        .seg_base(seg_base), .any_pending(any_pending)
    );

    coal_seg_gather #(
        .LANES(LANES), .ADDR_W(ADDR_W), .SEG_LSB(SEG_LSB), .WORDS(WORDS)
    ) u_gather (
        .lane_addr(addr_q), .pending(pending_q), .seg_base(seg_base),
        .hit(hit), .word_en(word_en)
    );

    // Handshake and output wiring.
    assign req_ready   = (state_q == ST_IDLE);
    assign txn_valid   = (state_q == ST_BUSY) && any_pending;
    assign txn_addr    = seg_base;
    assign txn_word_en = word_en;
    assign txn_store   = store_q;
    assign fire        = txn_valid && txn_ready;
    assign left        = pending_q & ~hit;
    assign done        = done_q;
    assign done_count  = done_cnt_q;

    // Request capture, lane retirement and completion sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            pending_q  <= '0;
            store_q    <= 1'b0;
            cnt_q      <= '0;
            done_q     <= 1'b0;
            done_cnt_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q    <= req_lane_addr;
                        pending_q <= req_mask;
                        store_q   <= req_store;
                        cnt_q     <= '0;
                        state_q   <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (!any_pending) begin
                        done_q     <= 1'b1;
                        done_cnt_q <= cnt_q;
                        state_q    <= ST_IDLE;
                    end else if (fire) begin
                        pending_q <= left;
                        cnt_q     <= cnt_q + CNT_W'(1);
                        if (left == '0) begin
                            done_q     <= 1'b1;
                            done_cnt_q <= cnt_q + CNT_W'(1);
                            state_q    <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/warp_coalescer_chk.sv
// Protocol checker for the coalescer, attached by bind. It tracks handshakes
// and the last issued address per request to check ordering and the count.
module warp_coalescer_chk #(
    parameter int ADDR_W  = 32,
    parameter int WORDS   = 32,
    parameter int SEG_LSB = 7,
    parameter int CNT_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [ADDR_W-1:0] txn_addr,
    input logic [WORDS-1:0]  txn_word_en,
    input logic              txn_store,
    input logic              done,
    input logic [CNT_W-1:0]  done_count
);
    logic [CNT_W-1:0]  seen_q;
    logic [ADDR_W-1:0] last_q;
    logic              have_last_q;

    // Count handshakes and remember the last issued segment of this request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= '0;
            last_q      <= '0;
            have_last_q <= 1'b0;
        end else if (done) begin
            seen_q      <= '0;
            have_last_q <= 1'b0;
        end else if (txn_valid && txn_ready) begin
            seen_q      <= seen_q + CNT_W'(1);
            last_q      <= txn_addr;
            have_last_q <= 1'b1;
        end
    end

    // R6
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready && have_last_q) |-> (txn_addr > last_q));

    // R7
    aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_addr[SEG_LSB-1:0] == '0 && txn_word_en != '0));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=>
            (txn_valid && $stable(txn_addr) && $stable(txn_word_en) && $stable(txn_store)));

    // R9
    count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_count == seen_q));

    // R9
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !txn_valid);
endmodule

bind warp_coalescer warp_coalescer_chk #(
    .ADDR_W(ADDR_W), .WORDS(WORDS), .SEG_LSB(SEG_LSB), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_addr(txn_addr), .txn_word_en(txn_word_en),
    .txn_store(txn_store), .done(done), .done_count(done_count)
);

// File: tb/warp_coalescer_test.sv
`timescale 1ns/1ps
module warp_coalescer_test;
    localparam int LANES = 32;
    localparam int AW    = 32;
    localparam int SEGB  = 128;
    localparam int WDS   = SEGB / 4;
    localparam int CW    = $clog2(LANES + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [LANES*AW-1:0] req_lane_addr = '0;
    logic [LANES-1:0]   req_mask = '0;
    logic               req_store = 1'b0;
    logic               txn_valid;
    logic               txn_ready = 1'b0;
    logic [AW-1:0]      txn_addr;
    logic [WDS-1:0]     txn_word_en;
    logic               txn_store;
    logic               done;
    logic [CW-1:0]      done_count;

    int tests = 0;
    int fails = 0;

    logic [AW-1:0]  lane_a [LANES];
    logic [AW-1:0]  obs_addr [64];
    logic [WDS-1:0] obs_en [64];
    int             nobs;
    int             last_done_count;

    always #2 clk = ~clk;

    warp_coalescer #(.LANES(LANES), .ADDR_W(AW), .SEG_BYTES(SEGB)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_lane_addr(req_lane_addr), .req_mask(req_mask), .req_store(req_store),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
        .txn_word_en(txn_word_en), .txn_store(txn_store), .done(done),
        .done_count(done_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] seg_of(input logic [AW-1:0] a);
        return a & ~AW'(SEGB - 1);
    endfunction

    // Number of distinct segments among active lanes.
    function automatic int ref_count(input logic [LANES-1:0] m);
        int n = 0;
        for (int i = 0; i < LANES; i++) begin
            bit dup = 0;
            for (int j = 0; j < i; j++)
                if (m[j] && seg_of(lane_a[j]) == seg_of(lane_a[i])) dup = 1;
            if (m[i] && !dup) n++;
        end
        return n;
    endfunction

    // Expected enable mask for a given segment.
    function automatic logic [WDS-1:0] ref_en(input logic [LANES-1:0] m,
                                              input logic [AW-1:0] seg);
        logic [WDS-1:0] e = '0;
        for (int i = 0; i < LANES; i++)
            if (m[i] && seg_of(lane_a[i]) == seg) e[(lane_a[i] % SEGB) / 4] = 1'b1;
        return e;
    endfunction

    // Drive one request, collect its transactions and check them.
    task automatic run_req(input logic [LANES-1:0] m, input bit st, input bit bp,
                           input string req);
        int  exp_n;
        int  cyc = 0;
        bit  got_done = 0;
        bit  fired_prev = 0;
        bit  stall = 0;
        bit  hold_ok = 1;
        bit  order_ok = 1;
        bit  en_ok = 1;
        bit  store_ok = 1;
        bit  timing_ok = 1;
        logic [AW-1:0]  s_addr = '0;
        logic [WDS-1:0] s_en = '0;
        for (int i = 0; i < LANES; i++) req_lane_addr[i*AW +: AW] = lane_a[i];
        req_mask  = m;
        req_store = st;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        nobs = 0;
        while (!got_done && cyc < 400) begin
            txn_ready = bp ? ($urandom % 3 != 0) : 1'b1;
            #0.5;
            if (stall && (!txn_valid || txn_addr != s_addr || txn_word_en != s_en)) hold_ok = 0;
            stall = 0;
            if (done) begin
                got_done = 1;
                last_done_count = int'(done_count);
                if (nobs > 0 && !fired_prev) timing_ok = 0;
            end else if (txn_valid) begin
                if (txn_store != st) store_ok = 0;
                if (txn_ready) begin
                    if (nobs < 64) begin
                        obs_addr[nobs] = txn_addr;
                        obs_en[nobs]   = txn_word_en;
                    end
                    nobs++;
                    fired_prev = 1;
                end else begin
                    stall = 1; s_addr = txn_addr; s_en = txn_word_en; fired_prev = 0;
                end
            end else fired_prev = 0;
            @(negedge clk);
            cyc++;
        end
        exp_n = ref_count(m);
        chk(got_done, req, "done seen (R9)", got_done, 1);
        chk(nobs == exp_n, req, "transaction count", nobs, exp_n);
        chk(last_done_count == exp_n, {req, " R9"}, "done_count", last_done_count, exp_n);
        for (int k = 0; k < nobs && k < 64; k++) begin
            if (k > 0 && obs_addr[k] <= obs_addr[k-1]) order_ok = 0;
            if (obs_en[k] != ref_en(m, obs_addr[k]) || obs_addr[k] != seg_of(obs_addr[k]))
                en_ok = 0;
        end
        chk(order_ok, {req, " R6"}, "ascending unique order", order_ok, 1);
        chk(en_ok, {req, " R7"}, "word enables", en_ok, 1);
        chk(store_ok, {req, " R10"}, "store flag", store_ok, 1);
        chk(timing_ok, {req, " R9"}, "done one cycle after last handshake", timing_ok, 1);
        if (bp) chk(hold_ok, {req, " R8"}, "hold under stall", hold_ok, 1);
        txn_ready = 1'b0;
    endtask

    task automatic set_pattern(input logic [AW-1:0] base, input int stride_words);
        for (int i = 0; i < LANES; i++) lane_a[i] = base + AW'(i * stride_words * 4);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cnt_a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(req_ready == 1'b1 && txn_valid == 1'b0 && done == 1'b0, "R11", "reset outputs",
            {req_ready, txn_valid, done}, 3'b100);

        // R1: aligned unit stride
        set_pattern(32'h0000_1000, 1);
        run_req('1, 0, 0, "R1");
        chk(nobs == 1 && obs_addr[0] == 32'h1000 && obs_en[0] == '1, "R1", "single full segment",
            obs_addr[0], 32'h1000);

        // R2: shifted by one word
        set_pattern(32'h0000_1004, 1);
        run_req('1, 0, 0, "R2");

        // R3: shifted by one whole segment
        set_pattern(32'h0000_1080, 1);
        run_req('1, 0, 1, "R3");
        chk(nobs == 1, "R3", "aligned offset count", nobs, 1);

        // R4: strides two and four
        set_pattern(32'h0000_2000, 2);
        run_req('1, 0, 0, "R4 stride2");
        chk(nobs == 2, "R4", "stride 2 count", nobs, 2);
        set_pattern(32'h0000_2000, 4);
        run_req('1, 0, 1, "R4 stride4");
        chk(nobs == 4, "R4", "stride 4 count", nobs, 4);

        // R5: empty mask and sparse mask
        set_pattern(32'h0000_3000, 8);
        run_req('0, 0, 0, "R5 empty");
        chk(nobs == 0 && last_done_count == 0, "R5", "empty request count", nobs, 0);
        run_req(32'h0000_0001, 0, 0, "R5 single lane");
        chk(nobs == 1 && obs_en[0] == WDS'(1), "R5", "single-lane enable", obs_en[0], 1);

        // R6: duplicate words, reverse order lanes
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h0000_5000 - AW'((i / 4) * SEGB);
        run_req('1, 0, 1, "R6 dup");
        chk(nobs == 8, "R6", "duplicate-lane segment count", nobs, 8);

        // R10: read-modify-write issues the set twice
        set_pattern(32'h0000_4004, 1);
        run_req('1, 0, 0, "R10 load");
        cnt_a = nobs;
        run_req('1, 1, 0, "R10 store");
        chk(nobs == cnt_a && nobs == 2, "R10", "store repeats load count", nobs, cnt_a);

        // Random mix under backpressure
        void'($urandom(32'h5eed_0c0a));
        for (int t = 0; t < 60; t++) begin
            int strides [6] = '{1, 2, 3, 4, 8, 32};
            logic [AW-1:0] b = ($urandom % 32'h10000) & ~32'h3;
            set_pattern(b, strides[$urandom % 6]);
            if ($urandom % 4 == 0)
                for (int i = 0; i < LANES; i++) lane_a[i] = b + AW'(($urandom % 512) * 4);
            run_req((t % 5 == 0) ? '1 : LANES'($urandom), 1'($urandom), 1, "R7 random");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule